// File: doc/BRIEF.md
# Two-Dimensional Memory DMA Channel

This block copies a run of elements from one region of memory to another. It uses a read side and a write side, and each side has its own address walker. Software sets up both sides through a register write port. It arms the source side first. It then writes the destination control word with the run and write-direction bits set, and the copy starts. Each element is read from the source address into a one-entry holding register and then written to the destination address. The destination therefore trails the source by exactly one element. Both sides advance by signed byte strides, so a negative stride walks a region backwards, for example to copy safely between overlapping regions.

In two-dimensional mode a transfer is a set of rows. At the end of a row the outer stride is applied instead of the inner stride and the inner counter reloads. The transfer holds inner count times outer count elements. The block checks the setup when the copy is armed and refuses a bad setup with an error flag. It reports completion, error and row completion through sticky flags. Software clears these flags by writing ones. An interrupt line follows whichever completion event the destination control word selects.

The memory side is a single request channel with valid/ready handshaking. A request, once valid, is held unchanged until ready is seen. Only one read is outstanding at a time. Its response comes back on `rsp_valid` any number of cycles later and cannot be back-pressured. Memory is addressed in 32-bit words, and byte enables select the lanes of a narrow write.

Top module: `mdma2d_chan`

## Requirements
- R1: After reset, `busy`, `stat_done`, `stat_err`, `stat_row`, `irq` and `mem_valid` are all 0.
- R2: Register map: `reg_addr[3]` selects the side (0 source, 1 destination), and `reg_addr[2:0]` selects the register: 0 start byte address, 1 inner count, 2 inner stride, 3 outer count, 4 outer stride, 5 control, 6 status clear. Control bits are: 0 run, 1 write-direction, 3:2 width, 4 two-dimensional, 5 interrupt enable, 6 row-interrupt select, 7 flush. A copy starts only when the destination control is written with run=1, write-direction=1 and flush=0 while the source control holds run=1. Any other control write starts nothing and issues no memory request.
- R3: In a one-dimensional copy, inner-count elements are moved. Each side's address advances by its own signed 16-bit inner stride after every element, so negative strides copy backwards.
- R4: The element width is taken from destination control bits 3:2: code 0 is 8 bits, 1 is 16 bits and 2 is 32 bits. An element at byte address A occupies bytes A onward, little-endian, in word A>>2. A write enables exactly the bytes of the element.
- R5: In two-dimensional mode (destination control bit 4), inner count times outer count elements are moved. After the last element of a row, each side adds its outer stride instead of its inner stride and reloads its inner counter.
- R6: A start is refused when any of these holds: the width code is 3; an inner count is 0; in two-dimensional mode an outer count is 0; a start address or an inner stride is not a multiple of the element size; or, in two-dimensional mode, an outer stride is not a multiple of the element size. A refused start sets ERR (status bit 1), issues no memory request and leaves `busy` at 0.
- R7: DONE (status bit 0) sets on the handshake of the final write, and `busy` falls at the same time.
- R8: Status bits are cleared by writing ones to status register 6 of either side. Writing zeros leaves them unchanged.
- R9: `irq` = interrupt enable AND (ERR OR (row-select ? ROW : DONE)). ROW is status bit 2. It sets after each row's last write only when row-select is 1.
- R10: While busy, a control write on either side with run=0 or flush=1 stops the channel at that clock edge. After it there are no further memory requests and DONE is not set.
- R11: A memory request stays stable while `mem_valid` is high and `mem_ready` is low. Each write carries the element returned by the read just before it.
- R12: Writes to start, count and stride registers are ignored while `busy` is high. A later copy uses the values held before the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Side select and register index |
| reg_wdata | input | 32 | Register write data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write data, element replicated over lanes |
| mem_be | output | 4 | Byte enables for writes |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data word |
| busy | output | 1 | Copy in progress |
| stat_done | output | 1 | Sticky transfer-complete flag |
| stat_err | output | 1 | Sticky setup-error flag |
| stat_row | output | 1 | Sticky row-complete flag |
| irq | output | 1 | Interrupt line |

## Verification
A wrong address or stride state in a walker shows up at `mem_addr` on the very next request. That is at most three cycles after the step that corrupted it. It then ends up as misplaced bytes in the destination region, which the bench compares against its own byte-level copy model. A wrong counter shows up as a missing or extra write, as a DONE that rises early or late, or as ROW flags at the wrong rows. A corrupted holding register shows up in `mem_wdata` on the write that follows the read. A broken setup check either lets requests escape after a bad start or fails to raise ERR within two cycles of the start.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef struct packed {
    logic       flush;
    logic       row_irq;
    logic       irq_en;
    logic       two_d;
    logic [1:0] width;
    logic       wnr;
    logic       run;
  } ctl_t;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RWAIT, S_WR} eng_st_e;

  localparam logic [2:0] RG_START = 3'd0;
  localparam logic [2:0] RG_ICNT  = 3'd1;
  localparam logic [2:0] RG_ISTR  = 3'd2;
  localparam logic [2:0] RG_OCNT  = 3'd3;
  localparam logic [2:0] RG_OSTR  = 3'd4;
  localparam logic [2:0] RG_CTL   = 3'd5;
  localparam logic [2:0] RG_STAT  = 3'd6;

  function automatic logic [2:0] elem_bytes(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] word, input logic [1:0] off,
                                            input logic [1:0] w);
    logic [31:0] sh;
    sh = word >> {off, 3'b000};
    case (w)
      2'd0:    return {24'd0, sh[7:0]};
      2'd1:    return {16'd0, sh[15:0]};
      default: return sh;
    endcase
  endfunction

  function automatic logic [31:0] lane_fill(input logic [31:0] d, input logic [1:0] w);
    case (w)
      2'd0:    return {4{d[7:0]}};
      2'd1:    return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [3:0] lane_be(input logic [1:0] off, input logic [1:0] w);
    case (w)
      2'd0:    return 4'b0001 << off;
      2'd1:    return 4'b0011 << off;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/mdma_regs.sv
module mdma_regs import mdma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [3:0]        addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              set_done,
  input  logic              set_err,
  input  logic              set_row,
  output logic [ADDR_W-1:0] start_o [2],
  output logic [CNT_W-1:0]  icnt_o  [2],
  output logic [STR_W-1:0]  istr_o  [2],
  output logic [CNT_W-1:0]  ocnt_o  [2],
  output logic [STR_W-1:0]  ostr_o  [2],
  output ctl_t              ctl_o   [2],
  output logic              go_o,
  output logic              stop_o,
  output logic [2:0]        stat_o
);

  ctl_t wctl;
  logic ctl_hit, stat_hit;
  assign wctl     = ctl_t'(wdata[7:0]);
  assign ctl_hit  = we && (addr[2:0] == RG_CTL);
  assign stat_hit = we && (addr[2:0] == RG_STAT);
  // stop acts at the same edge as the write that requests it
  assign stop_o   = ctl_hit && busy && (!wctl.run || wctl.flush);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        start_o[s] <= '0;
        icnt_o[s]  <= '0;
        istr_o[s]  <= '0;
        ocnt_o[s]  <= '0;
        ostr_o[s]  <= '0;
        ctl_o[s]   <= '0;
      end
      go_o   <= 1'b0;
      stat_o <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (we && addr[3] == 1'(s)) begin
          case (addr[2:0])
            RG_START: if (!busy) start_o[s] <= wdata[ADDR_W-1:0];
            RG_ICNT:  if (!busy) icnt_o[s]  <= wdata[CNT_W-1:0];
            RG_ISTR:  if (!busy) istr_o[s]  <= wdata[STR_W-1:0];
            RG_OCNT:  if (!busy) ocnt_o[s]  <= wdata[CNT_W-1:0];
            RG_OSTR:  if (!busy) ostr_o[s]  <= wdata[STR_W-1:0];
            RG_CTL:   if (!busy || !wctl.run || wctl.flush)
                        ctl_o[s] <= ctl_t'({1'b0, wdata[6:0]});
            default: ;
          endcase
        end
      end
      go_o   <= ctl_hit && addr[3] && wctl.run && wctl.wnr && !wctl.flush
                && ctl_o[0].run && !busy;
      stat_o <= (stat_o & ~(stat_hit ? wdata[2:0] : 3'b000)) | {set_row, set_err, set_done};
    end
  end

  a_r8_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hit && wdata[0] && !set_done |=> !stat_o[0]);
  a_r12_start_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && we && addr == 4'h0 |=> $stable(start_o[0]));

endmodule

// File: rtl/mdma_walk.sv
module mdma_walk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              two_d,
  input  logic [ADDR_W-1:0] start,
  input  logic [CNT_W-1:0]  icnt,
  input  logic [STR_W-1:0]  istr,
  input  logic [CNT_W-1:0]  ocnt,
  input  logic [STR_W-1:0]  ostr,
  output logic [ADDR_W-1:0] addr,
  output logic              row_end,
  output logic              last
);

  localparam int EXT_W = ADDR_W - STR_W;

  logic [CNT_W-1:0]  ic_q, oc_q;
  logic [ADDR_W-1:0] istr_x, ostr_x;

  assign istr_x  = {{EXT_W{istr[STR_W-1]}}, istr};
  assign ostr_x  = {{EXT_W{ostr[STR_W-1]}}, ostr};
  assign row_end = (ic_q == CNT_W'(1));
  assign last    = row_end && (!two_d || oc_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      ic_q <= '0;
      oc_q <= '0;
    end else if (load) begin
      addr <= start;
      ic_q <= icnt;
      oc_q <= ocnt;
    end else if (step) begin
      if (row_end) begin
        if (!last) begin
          addr <= addr + ostr_x;
          ic_q <= icnt;
          oc_q <= oc_q - CNT_W'(1);
        end
      end else begin
        addr <= addr + istr_x;
        ic_q <= ic_q - CNT_W'(1);
      end
    end
  end

  a_r5_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ic_q != '0);

endmodule

// File: rtl/mdma_engine.sv
module mdma_engine import mdma_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              stop,
  input  logic              cfg_ok,
  input  logic [1:0]        width,
  input  logic              row_irq,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              dst_row_end,
  input  logic              dst_last,
  input  logic              mem_ready,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  output logic              load,
  output logic              src_step,
  output logic              dst_step,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  output logic              busy,
  output logic              set_done,
  output logic              set_err,
  output logic              set_row
);

  eng_st_e     st_q;
  logic [31:0] hold_q;
  logic        wr_hs;

  assign busy      = (st_q != S_IDLE);
  assign mem_valid = (st_q == S_RD) || (st_q == S_WR);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = mem_we ? dst_addr[ADDR_W-1:2] : src_addr[ADDR_W-1:2];
  assign mem_wdata = lane_fill(hold_q, width);
  assign mem_be    = mem_we ? lane_be(dst_addr[1:0], width) : 4'b1111;

  assign wr_hs    = (st_q == S_WR) && mem_ready && !stop;
  assign load     = (st_q == S_IDLE) && go && cfg_ok;
  assign set_err  = (st_q == S_IDLE) && go && !cfg_ok;
  assign src_step = (st_q == S_RWAIT) && rsp_valid && !stop;
  assign dst_step = wr_hs;
  assign set_done = wr_hs && dst_last;
  assign set_row  = wr_hs && dst_row_end && row_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      hold_q <= '0;
    end else if (stop) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_IDLE:  if (load) st_q <= S_RD;
        S_RD:    if (mem_ready) st_q <= S_RWAIT;
        S_RWAIT: if (rsp_valid) begin
                   hold_q <= lane_pick(rsp_data, src_addr[1:0], width);
                   st_q   <= S_WR;
                 end
        S_WR:    if (mem_ready) st_q <= dst_last ? S_IDLE : S_RD;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && !stop |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                         && $stable(mem_wdata));
  a_r6_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> !busy);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> !busy);
  a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !mem_valid);
  a_r4_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> $countones(mem_be) == int'(elem_bytes(width)));

endmodule

// File: rtl/mdma2d_chan.sv
module mdma2d_chan import mdma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  output logic              busy,
  output logic              stat_done,
  output logic              stat_err,
  output logic              stat_row,
  output logic              irq
);

  logic [ADDR_W-1:0] start [2];
  logic [CNT_W-1:0]  icnt  [2];
  logic [STR_W-1:0]  istr  [2];
  logic [CNT_W-1:0]  ocnt  [2];
  logic [STR_W-1:0]  ostr  [2];
  ctl_t              ctl   [2];
  logic [ADDR_W-1:0] waddr [2];
  logic              row_end [2];
  logic              last    [2];
  logic              go, stop, load, src_step, dst_step, cfg_ok;
  logic              set_done, set_err, set_row;
  logic [2:0]        stat;
  logic [1:0]        lowmask;
  logic              two_d;

  assign two_d = ctl[1].two_d;

  mdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STR_W(STR_W)) u_regs (
    .clk, .rst_n, .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .busy,
    .set_done, .set_err, .set_row,
    .start_o(start), .icnt_o(icnt), .istr_o(istr), .ocnt_o(ocnt), .ostr_o(ostr),
    .ctl_o(ctl), .go_o(go), .stop_o(stop), .stat_o(stat)
  );

  for (genvar s = 0; s < 2; s++) begin : g_walk
    mdma_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STR_W(STR_W)) u_walk (
      .clk, .rst_n, .load, .step(s == 0 ? src_step : dst_step), .two_d,
      .start(start[s]), .icnt(icnt[s]), .istr(istr[s]), .ocnt(ocnt[s]), .ostr(ostr[s]),
      .addr(waddr[s]), .row_end(row_end[s]), .last(last[s])
    );
  end

  // setup check done once, when the copy is armed
  always_comb begin
    case (ctl[1].width)
      2'd0:    lowmask = 2'b00;
      2'd1:    lowmask = 2'b01;
      default: lowmask = 2'b11;
    endcase
    cfg_ok = (ctl[1].width != 2'd3)
          && (icnt[0] != '0) && (icnt[1] != '0)
          && (!two_d || ((ocnt[0] != '0) && (ocnt[1] != '0)))
          && (((start[0][1:0] | start[1][1:0] | istr[0][1:0] | istr[1][1:0]) & lowmask) == 2'b00)
          && (!two_d || (((ostr[0][1:0] | ostr[1][1:0]) & lowmask) == 2'b00));
  end

  mdma_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk, .rst_n, .go, .stop, .cfg_ok, .width(ctl[1].width), .row_irq(ctl[1].row_irq),
    .src_addr(waddr[0]), .dst_addr(waddr[1]), .dst_row_end(row_end[1]), .dst_last(last[1]),
    .mem_ready, .rsp_valid, .rsp_data, .load, .src_step, .dst_step,
    .mem_valid, .mem_we, .mem_addr, .mem_wdata, .mem_be, .busy,
    .set_done, .set_err, .set_row
  );

  assign stat_done = stat[0];
  assign stat_err  = stat[1];
  assign stat_row  = stat[2];
  assign irq       = ctl[1].irq_en && (stat_err || (ctl[1].row_irq ? stat_row : stat_done));

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_err || stat_done || stat_row));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

endmodule

// File: tb/mdma2d_chan_tb.sv
module mdma2d_chan_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        busy, stat_done, stat_err, stat_row, irq;

  logic [7:0]  mem_b [0:1023];
  logic [7:0]  exp_b [0:1023];
  int          checks = 0, fails = 0, req_cnt = 0, stall_bad = 0;
  logic        stalled = 1'b0;
  logic [29:0] st_addr;
  logic        st_we;
  logic [31:0] st_wd;
  bit          reported = 0;

  localparam int C_RUN = 1, C_WNR = 2, C_2D = 16, C_IEN = 32, C_ROW = 64, C_FLUSH = 128;

  mdma2d_chan u_dut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .mem_valid, .mem_ready, .mem_we,
    .mem_addr, .mem_wdata, .mem_be, .rsp_valid, .rsp_data, .busy, .stat_done,
    .stat_err, .stat_row, .irq
  );

  // memory model: one-cycle read latency, random ready
  always @(posedge clk) begin
    int base;
    if (stalled && mem_valid &&
        (mem_addr !== st_addr || mem_we !== st_we || mem_wdata !== st_wd))
      stall_bad++;
    stalled <= mem_valid && !mem_ready;
    st_addr <= mem_addr;
    st_we   <= mem_we;
    st_wd   <= mem_wdata;
    rsp_valid <= 1'b0;
    if (mem_valid && mem_ready) begin
      req_cnt++;
      base = {mem_addr[7:0], 2'b00};
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem_b[base + k] <= mem_wdata[8*k +: 8];
      end else begin
        rsp_valid <= 1'b1;
        rsp_data  <= {mem_b[base + 3], mem_b[base + 2], mem_b[base + 1], mem_b[base]};
      end
    end
    mem_ready <= ($urandom % 4) != 0;
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fill();
    logic [7:0] v;
    for (int i = 0; i < 1024; i++) begin
      v = 8'($urandom);
      mem_b[i] = v;
      exp_b[i] = v;
    end
  endtask

  task automatic prog(input int sa, input int si, input int so, input int da, input int di,
                      input int dso, input int ni, input int no);
    wr(4'h0, sa); wr(4'h1, ni); wr(4'h2, si); wr(4'h3, no); wr(4'h4, so);
    wr(4'h8, da); wr(4'h9, ni); wr(4'hA, di); wr(4'hB, no); wr(4'hC, dso);
  endtask

  task automatic ref_copy(input int sa0, input int si, input int so, input int da0,
                          input int di, input int dso, input int ni, input int no, input int b);
    int sa, da;
    sa = sa0; da = da0;
    for (int o = 0; o < no; o++)
      for (int i = 0; i < ni; i++) begin
        for (int k = 0; k < b; k++) exp_b[(da + k) & 1023] = exp_b[(sa + k) & 1023];
        if (i == ni - 1) begin sa += so; da += dso; end
        else begin sa += si; da += di; end
      end
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    repeat (3) @(negedge clk);
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
  endtask

  task automatic xfer(input int ctl);
    wr(4'h5, C_RUN);
    wr(4'hD, ctl);
    wait_idle();
  endtask

  task automatic cmp_mem(input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int i = 0; i < 1024; i++)
      if (mem_b[i] !== exp_b[i]) begin bad++; if (first < 0) first = i; end
    chk(req, bad, 0);
    if (bad != 0) $display("  first mismatch at byte %0d", first);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    int rc, w, b, ni, no, two, si, di, so, dso, sa, da, ctl;
    void'($urandom(32'd20240607));
    fill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 status", {stat_row, stat_err, stat_done}, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mem_valid", mem_valid, 0);

    // R3 R4 R7: 32-bit forward 1D copy
    prog(32'h40, 4, 0, 32'h200, 4, 0, 8, 1);
    ref_copy(32'h40, 4, 0, 32'h200, 4, 0, 8, 1, 4);
    xfer(C_RUN | C_WNR | (2 << 2));
    cmp_mem("R3 forward 32-bit copy");
    chk("R7 done", stat_done, 1);
    chk("R7 busy low", busy, 0);
    chk("R9 irq disabled", irq, 0);

    // R8 write-one-to-clear
    wr(4'h6, 0);
    chk("R8 zero write keeps done", stat_done, 1);
    wr(4'hE, 1);
    chk("R8 one clears done", stat_done, 0);

    // R3 R4 backwards overlapping 8-bit copy
    prog(32'h10F, -1, 0, 32'h113, -1, 0, 12, 1);
    ref_copy(32'h10F, -1, 0, 32'h113, -1, 0, 12, 1, 1);
    xfer(C_RUN | C_WNR | C_IEN);
    cmp_mem("R3 backward overlapping byte copy");
    chk("R9 irq on done", irq, 1);
    wr(4'h6, 7);

    // R4 16-bit lanes with odd half-word position
    prog(32'h302, 6, 0, 32'h382, 2, 0, 5, 1);
    ref_copy(32'h302, 6, 0, 32'h382, 2, 0, 5, 1, 2);
    xfer(C_RUN | C_WNR | (1 << 2));
    cmp_mem("R4 half-word copy");
    wr(4'h6, 7);

    // R5 R9 2D with row flag
    prog(32'h80, 4, 64, 32'h240, 4, -20, 3, 4);
    ref_copy(32'h80, 4, 64, 32'h240, 4, -20, 3, 4, 4);
    xfer(C_RUN | C_WNR | (2 << 2) | C_2D | C_IEN | C_ROW);
    cmp_mem("R5 2D copy with outer strides");
    chk("R9 row flag", stat_row, 1);
    chk("R9 irq in row mode", irq, 1);
    wr(4'h6, 4);
    chk("R9 irq ignores done in row mode", {irq, stat_done}, 2'b01);
    wr(4'h6, 7);

    // R2 start rules
    rc = req_cnt;
    wr(4'h5, 0);
    wr(4'hD, C_RUN | C_WNR | (2 << 2));
    repeat (4) @(negedge clk);
    chk("R2 no start without source run", {busy, 1'b0}, 0);
    wr(4'h5, C_RUN);
    wr(4'hD, C_RUN | (2 << 2));
    repeat (4) @(negedge clk);
    chk("R2 no start without write direction", busy, 0);
    chk("R2 no requests", req_cnt - rc, 0);

    // R6 setup errors
    for (int c = 0; c < 5; c++) begin
      wr(4'h6, 7);
      prog(c == 4 ? 32'h42 : 32'h40, c == 1 ? 2 : 4, 4, 32'h200, 4, 4,
           c == 2 ? 0 : 4, c == 3 ? 0 : 2);
      rc = req_cnt;
      wr(4'h5, C_RUN);
      wr(4'hD, C_RUN | C_WNR | C_2D | C_IEN | ((c == 0 ? 3 : 2) << 2));
      repeat (4) @(negedge clk);
      chk($sformatf("R6 err case %0d", c), stat_err, 1);
      chk($sformatf("R6 busy case %0d", c), busy, 0);
      chk($sformatf("R6 no requests case %0d", c), req_cnt - rc, 0);
      chk($sformatf("R9 irq on err case %0d", c), irq, 1);
    end
    wr(4'h6, 7);

    // R10 stop while busy
    fill();
    prog(0, 4, 0, 32'h200, 4, 0, 100, 1);
    wr(4'h5, C_RUN);
    wr(4'hD, C_RUN | C_WNR | (2 << 2));
    repeat (20) @(negedge clk);
    wr(4'h5, 0);
    chk("R10 busy after stop", busy, 0);
    rc = req_cnt;
    repeat (10) @(negedge clk);
    chk("R10 no requests after stop", req_cnt - rc, 0);
    chk("R10 done not set", stat_done, 0);
    wr(4'h6, 7);

    // R12 register writes ignored while busy
    fill();
    prog(32'h40, 4, 0, 32'h100, 4, 0, 8, 1);
    ref_copy(32'h40, 4, 0, 32'h100, 4, 0, 8, 1, 4);
    wr(4'h5, C_RUN);
    wr(4'hD, C_RUN | C_WNR | (2 << 2));
    repeat (2) @(negedge clk);
    wr(4'h0, 32'h300);
    wait_idle();
    cmp_mem("R12 first copy");
    for (int i = 0; i < 32; i++) begin
      mem_b[32'h40 + i] = 8'($urandom);
      exp_b[32'h40 + i] = mem_b[32'h40 + i];
    end
    ref_copy(32'h40, 4, 0, 32'h100, 4, 0, 8, 1, 4);
    wr(4'hD, C_RUN | C_WNR | (2 << 2));
    wait_idle();
    cmp_mem("R12 rerun uses held start address");
    wr(4'h6, 7);

    // random mix: R3 R4 R5 R11
    for (int t = 0; t < 20; t++) begin
      w = $urandom % 3; b = 1 << w;
      two = $urandom % 2;
      ni = 1 + $urandom % 6;
      no = two ? 1 + $urandom % 4 : 1;
      si  = (($urandom % 2) ? -b : b) * (1 + $urandom % 2);
      di  = (($urandom % 2) ? -b : b) * (1 + $urandom % 2);
      so  = (($urandom % 2) ? -b : b) * ($urandom % 9);
      dso = (($urandom % 2) ? -b : b) * ($urandom % 9);
      sa = 256 + b * ($urandom % 8);
      da = 768 - b * ($urandom % 8);
      ctl = C_RUN | C_WNR | (w << 2) | (two ? C_2D : 0);
      fill();
      prog(sa, si, so, da, di, dso, ni, no);
      ref_copy(sa, si, so, da, di, dso, ni, no, b);
      xfer(ctl);
      cmp_mem($sformatf("R5 random transfer %0d", t));
      chk($sformatf("R7 random done %0d", t), {stat_err, stat_done}, 2'b01);
      wr(4'h6, 7);
    end
    chk("R11 request stable under stall", stall_bad, 0);
    report();
  end

endmodule